// File: doc/BRIEF.md
# Three-Port Parallel I/O (Basic Mode)

This block provides 24 general-purpose digital lines arranged as three 8-bit ports, A, B and C, reached over an 8-bit data bus with a 2-bit register address. A fourth address holds a write-only setup register that picks, for each port, whether it drives or listens. Port C is split into an upper and a lower nibble, and each nibble has its own direction. Only the plain latched-output / live-input mode is provided. Port C never carries handshake or strobe signals.

Writes to a port address land in that port's output latch. Reads are combinational from the current state: a line set as output reads back its latch, and a line set as input reads back the pin level present in that cycle, with no sampling register. Every accepted setup write reloads all four direction bits and clears all three output latches. Separate output-enable signals for A, B and each nibble of C let the surrounding chip build tristate pads.

Top module: `pio3_mode0`

## Requirements
- R1: After synchronous reset all four output enables are low (every line is an input) and all three output latches hold 0.
- R2: Register address 0 selects port A, 1 port B, 2 port C and 3 the setup register. A read of address 3 returns 0x00.
- R3: A bus write to address 0, 1 or 2 loads that port's output latch at the clock edge. The latch appears on the port's output pins, and a read of an output-mode port returns the latch.
- R4: A setup write whose bit 7 is 1 loads the directions: bit 4 sets port A, bit 3 sets the upper nibble of C, bit 1 sets port B and bit 0 sets the lower nibble of C. A 1 makes the lines inputs (enable low) and a 0 makes them outputs (enable high).
- R5: Every setup write with bit 7 set clears all three output latches to 0.
- R6: A setup write with bit 7 clear changes neither the directions nor any latch.
- R7: A read of an input-mode port returns the pin levels of that same cycle.
- R8: The two nibbles of port C are independent: a read of C takes each nibble from its pins or from its latch according to that nibble's direction.
- R9: Setup value 0x9B makes all lines inputs, 0x80 makes all lines outputs, and 0x92 makes A and B inputs with both nibbles of C outputs.
- R10: A read of a port in the same cycle as a write to it returns the value the latch held before that write. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| pa_i | input | 8 | Port A pin levels |
| pb_i | input | 8 | Port B pin levels |
| pc_i | input | 8 | Port C pin levels |
| pa_o | output | 8 | Port A output latch |
| pb_o | output | 8 | Port B output latch |
| pc_o | output | 8 | Port C output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_oe | output | 1 | Port B drive enable |
| pc_hi_oe | output | 1 | Port C bits 7..4 drive enable |
| pc_lo_oe | output | 1 | Port C bits 3..0 drive enable |

## Verification
The functions that can fall in the same cycle are a latch write and a combinational read of the same port. The bench raises the write strobe at a falling edge with the address on port A. It reads the data bus before the next rising edge, where it must still show the old latch, and reads again after that edge, where it must show the new value. The mixed-direction tests on port C also drive pin values that differ from the latch, so that a nibble routed to the wrong source is detected.

// File: rtl/pio3_pkg.sv
package pio3_pkg;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CFG = 2'd3
    } sel_e;

    // Direction state: 1 = listening (input), 0 = driving (output)
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic ch_in;
        logic cl_in;
    } dir_t;

    localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, ch_in: 1'b1, cl_in: 1'b1};

    // Bit positions inside the setup byte
    localparam int CFG_MODE_BIT = 7;
    localparam int CFG_A_BIT    = 4;
    localparam int CFG_CH_BIT   = 3;
    localparam int CFG_B_BIT    = 1;
    localparam int CFG_CL_BIT   = 0;

    function automatic dir_t make_dir(input logic a, input logic b,
                                      input logic ch, input logic cl);
        dir_t d;
        d.a_in  = a;
        d.b_in  = b;
        d.ch_in = ch;
        d.cl_in = cl;
        return d;
    endfunction

endpackage

// File: rtl/pio3_cfg.sv
module pio3_cfg
    import pio3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,     // any write to the setup address
    input  logic cfg_mode,   // bit 7 of that write
    input  dir_t dir_req,
    output dir_t dir,
    output logic accept      // accepted setup write this cycle
);

    assign accept = cfg_wr && cfg_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir <= DIR_RESET;
        end else if (accept) begin
            dir <= dir_req;
        end
    end

    AST_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr && !cfg_mode) && !$past(rst) |-> dir == $past(dir)); // R6

    AST_CFG_LOADS: assert property (@(posedge clk) disable iff (rst)
        $past(accept) && !$past(rst) |-> dir == $past(dir_req)); // R4

endmodule

// File: rtl/pio3_port.sv
module pio3_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    input  logic         dir_hi,   // 1 = upper half is input
    input  logic         dir_lo,   // 1 = lower half is input
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] rd_o
);

    localparam int H = W / 2;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            latch_o <= '0;
        end else if (wr) begin
            latch_o <= wdata;
        end
    end

    // Read path: each half picks live pins or its latch
    generate
        for (genvar g = 0; g < 2; g++) begin : g_half
            localparam int LO = g * H;
            localparam int HW = (g == 1) ? (W - H) : H;
            logic sel_in;
            assign sel_in = (g == 1) ? dir_hi : dir_lo;
            assign rd_o[LO +: HW] = sel_in ? pin_i[LO +: HW] : latch_o[LO +: HW];
        end
    endgenerate

    AST_CLEAR_ON_SETUP: assert property (@(posedge clk) disable iff (rst)
        $past(clr) && !$past(rst) |-> latch_o == '0); // R5

    AST_WRITE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        $past(wr && !clr) && !$past(rst) |-> latch_o == $past(wdata)); // R3

endmodule

// File: rtl/pio3_mode0.sv
module pio3_mode0
    import pio3_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pa_i,
    input  logic [DW-1:0] pb_i,
    input  logic [DW-1:0] pc_i,
    output logic [DW-1:0] pa_o,
    output logic [DW-1:0] pb_o,
    output logic [DW-1:0] pc_o,
    output logic          pa_oe,
    output logic          pb_oe,
    output logic          pc_hi_oe,
    output logic          pc_lo_oe
);

    sel_e          sel;
    dir_t          dir, dir_req;
    logic          cfg_wr, cfg_accept;
    logic [DW-1:0] rd_a, rd_b, rd_c;

    assign sel     = sel_e'(bus_addr);
    assign cfg_wr  = bus_wr && (sel == SEL_CFG);
    assign dir_req = make_dir(bus_wdata[CFG_A_BIT], bus_wdata[CFG_B_BIT],
                              bus_wdata[CFG_CH_BIT], bus_wdata[CFG_CL_BIT]);

    pio3_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_mode (bus_wdata[CFG_MODE_BIT]),
        .dir_req  (dir_req),
        .dir      (dir),
        .accept   (cfg_accept)
    );

    pio3_port #(.W(DW)) u_port_a (
        .clk(clk), .rst(rst), .wr(bus_wr && sel == SEL_A), .clr(cfg_accept),
        .wdata(bus_wdata), .dir_hi(dir.a_in), .dir_lo(dir.a_in),
        .pin_i(pa_i), .latch_o(pa_o), .rd_o(rd_a)
    );

    pio3_port #(.W(DW)) u_port_b (
        .clk(clk), .rst(rst), .wr(bus_wr && sel == SEL_B), .clr(cfg_accept),
        .wdata(bus_wdata), .dir_hi(dir.b_in), .dir_lo(dir.b_in),
        .pin_i(pb_i), .latch_o(pb_o), .rd_o(rd_b)
    );

    pio3_port #(.W(DW)) u_port_c (
        .clk(clk), .rst(rst), .wr(bus_wr && sel == SEL_C), .clr(cfg_accept),
        .wdata(bus_wdata), .dir_hi(dir.ch_in), .dir_lo(dir.cl_in),
        .pin_i(pc_i), .latch_o(pc_o), .rd_o(rd_c)
    );

    assign pa_oe    = !dir.a_in;
    assign pb_oe    = !dir.b_in;
    assign pc_hi_oe = !dir.ch_in;
    assign pc_lo_oe = !dir.cl_in;

    always_comb begin
        unique case (sel)
            SEL_A:   bus_rdata = rd_a;
            SEL_B:   bus_rdata = rd_b;
            SEL_C:   bus_rdata = rd_c;
            default: bus_rdata = '0;
        endcase
    end

    AST_INPUT_LIVE: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0 && !pa_oe) |-> bus_rdata == pa_i); // R7

    AST_OUTPUT_READBACK: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1 && pb_oe) |-> bus_rdata == pb_o); // R3

    AST_SETUP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> bus_rdata == '0); // R2

    AST_ENABLE_FROM_BIT4: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == 2'd3 && bus_wdata[7]) && !$past(rst)
        |-> pa_oe == !$past(bus_wdata[4])); // R4

endmodule

// File: tb/pio3_mode0_tb.sv
module pio3_mode0_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
    logic [7:0] pa_o, pb_o, pc_o;
    logic       pa_oe, pb_oe, pc_hi_oe, pc_lo_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pio3_mode0 dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_i(pa_i), .pb_i(pb_i), .pc_i(pc_i),
        .pa_o(pa_o), .pb_o(pb_o), .pc_o(pc_o),
        .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_hi_oe(pc_hi_oe), .pc_lo_oe(pc_lo_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] oes();
        return {4'h0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe};
    endfunction

    task automatic t_reset();
        logic [7:0] r;
        chk("R1 enables", oes(), 8'h00);
        chk("R1 latches", pa_o | pb_o | pc_o, 8'h00);
        pa_i = 8'h5A;
        bus_read(2'd0, r);
        chk("R7 live read A", r, 8'h5A);
        pa_i = 8'hC3;
        bus_read(2'd0, r);
        chk("R7 live read A changed", r, 8'hC3);
    endtask

    task automatic t_all_out();
        logic [7:0] r;
        bus_write(2'd3, 8'h80);
        chk("R9 0x80 enables", oes(), 8'h0F);
        pa_i = 8'hFF; pb_i = 8'hFF; pc_i = 8'hFF;
        bus_write(2'd0, 8'h11);
        bus_write(2'd1, 8'h22);
        bus_write(2'd2, 8'h33);
        chk("R3 pin A", pa_o, 8'h11);
        chk("R3 pin B", pb_o, 8'h22);
        chk("R3 pin C", pc_o, 8'h33);
        bus_read(2'd0, r); chk("R2 R3 read A", r, 8'h11);
        bus_read(2'd1, r); chk("R2 R3 read B", r, 8'h22);
        bus_read(2'd2, r); chk("R2 R3 read C", r, 8'h33);
        bus_read(2'd3, r); chk("R2 read setup", r, 8'h00);
    endtask

    task automatic t_clear();
        bus_write(2'd3, 8'h80);
        chk("R5 clear A", pa_o, 8'h00);
        chk("R5 clear B", pb_o, 8'h00);
        chk("R5 clear C", pc_o, 8'h00);
        chk("R4 R5 enables kept", oes(), 8'h0F);
    endtask

    task automatic t_ignored();
        bus_write(2'd0, 8'hAA);
        bus_write(2'd3, 8'h1B);
        chk("R6 enables unchanged", oes(), 8'h0F);
        chk("R6 latch A unchanged", pa_o, 8'hAA);
    endtask

    task automatic t_mixed();
        logic [7:0] r;
        bus_write(2'd3, 8'h92);
        chk("R9 0x92 enables", oes(), 8'h03);
        bus_write(2'd3, 8'h9B);
        chk("R9 0x9B enables", oes(), 8'h00);
        bus_write(2'd3, 8'h88);
        chk("R4 R8 0x88 enables", oes(), 8'h0D);
        bus_write(2'd2, 8'h5C);
        pc_i = 8'hA3;
        bus_read(2'd2, r);
        chk("R8 C hi pins lo latch", r, 8'hAC);
        bus_write(2'd3, 8'h81);
        chk("R4 R8 0x81 enables", oes(), 8'h0E);
        bus_write(2'd2, 8'h5C);
        bus_read(2'd2, r);
        chk("R8 C hi latch lo pins", r, 8'h53);
        bus_write(2'd3, 8'h90);
        pb_i = 8'h0F;
        bus_write(2'd1, 8'h77);
        bus_read(2'd1, r);
        chk("R4 B output readback", r, 8'h77);
        bus_read(2'd0, r);
        pa_i = 8'h6E;
        bus_read(2'd0, r);
        chk("R7 A input under 0x90", r, 8'h6E);
    endtask

    task automatic t_same_cycle();
        logic [7:0] r;
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h3C);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'hC3; bus_wr = 1'b1;
        #1;
        r = bus_rdata;
        chk("R10 read before edge", r, 8'h3C);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R10 read after edge", bus_rdata, 8'hC3);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_all_out();
        t_clear();
        t_ignored();
        t_mixed();
        t_same_cycle();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule